// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block receives start/stop framed characters from a single serial line. The line is sampled at sixteen times the bit rate, qualified by an enable pulse, and each bit is taken near its centre. A start bit is accepted only if the line is still low at its middle sample, so short glitches are rejected. Eight data bits arrive least significant bit first. They may be followed by a parity bit, with even or odd sense chosen by configuration. One or two stop bits follow.

Three sticky flags report each finished character: data-full, parity error and framing error. A clean character loads the data register and sets data-full. A character that fails parity or framing is still loaded into the data register, but data-full stays clear and the matching error flag is set. While either error flag is set, the receiver accepts no new character. Software clears any flag by a two-step handshake. It must first read the status while the flag is 1, and then write a 0 to that bit. Dropping receive-enable stops reception but leaves every flag as it is. A standby input clears the flags at once.

Top module: `rxChannel`

## Requirements
- R1: The line passes through a two-stage synchronizer and is sampled once per `tick16` pulse. A low level opens a candidate start bit. The candidate is kept only if the line is still low eight ticks later; otherwise the receiver returns to idle and the flags and data are unchanged.
- R2: Each data bit is sampled sixteen ticks after the previous sample. Eight bits are assembled with the first received bit in bit 0. A clean character stores them in the data register and sets data-full, which is status bit 0.
- R3: With `parityEn`=1, one parity bit follows the data. The parity error flag, status bit 1, is set when the count of ones in the data plus the parity bit is odd while `parityOdd`=0, or even while `parityOdd`=1. With `parityEn`=0, no parity bit is expected and the flag is never set.
- R4: The framing error flag, status bit 2, is set when the first stop bit samples 0. With `twoStop`=1, the level of the second stop bit is ignored and does not start a new character.
- R5: A character with a parity or framing error is still written to the data register, but data-full is not set.
- R6: While status bit 1 or bit 2 is 1, no new character is received. Reception resumes only after both bits are 0.
- R7: A status flag clears only when a status write carries 0 in its bit and software has read that flag as 1 since the flag was last set. Writing a 1, or writing a 0 without that prior read, leaves the flag unchanged.
- R8: While `rxEnable`=0, nothing is received and no flag changes.
- R9: Reset and the `standby` input force all three flags to 0.
- R10: Bus reads are combinational. Address 0 returns the data register. Address 1 returns {5'b0, framing, parity, data-full}. Writes take effect only at address 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Standby / module stop; clears the flags and idles the receiver |
| tick16 | input | 1 | Sampling enable at sixteen times the bit rate |
| serialIn | input | 1 | Serial receive line, idle high |
| rxEnable | input | 1 | Receive enable |
| parityEn | input | 1 | Expect a parity bit after the data |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| twoStop | input | 1 | 1 selects two stop bits |
| busSel | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 1 | 0 selects the data register, 1 selects status |
| busWdata | input | 3 | Status write data, one bit per flag |
| busRdata | output | 8 | Read data |

## Verification
The bench targets four groups of behaviour, and names the fault each one exposes.

- **Clear handshake.** The bench writes 0 without a prior read, and writes 1 to bits that are already set. A design without the read-arming rule would drop a flag on the first write.
- **Freeze after an error.** A clean frame is sent while an error flag is set. A receiver that keeps running would overwrite the stored faulty character or raise data-full. Clearing only one of two simultaneous error flags must keep the receiver frozen.
- **Two stop bits.** A low second stop bit is sent. A design that checks the wrong stop bit would report a framing error, and one that returns to idle too early would see a false start.
- **Glitches, receive-enable and standby.** A short low glitch must not produce a character. Dropping receive-enable must leave a set flag in place, and standby must clear the flags.

// File: rtl/rxPkg.sv
package rxPkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_STOP2
  } rxStateT;

  // strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic shiftBit;    // take a data bit
    logic takeParity;  // take the parity bit
    logic finish;      // first stop bit sampled, character complete
  } rxStrobeT;

  localparam int FLAG_FULL  = 0;
  localparam int FLAG_PAR   = 1;
  localparam int FLAG_FRAME = 2;
  localparam int FLAG_COUNT = 3;
endpackage

// File: rtl/rxCtrl.sv
module rxCtrl
  import rxPkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     standby,
  input  logic     tick,
  input  logic     serialIn,
  input  logic     rxEnable,
  input  logic     parityEn,
  input  logic     twoStop,
  input  logic     errAny,
  output rxStrobeT strobe,
  output logic     lineSync
);
  localparam int HALF = OVERSAMPLE / 2;
  localparam int PHW  = $clog2(OVERSAMPLE + HALF);
  localparam int BIW  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  rxStateT        state;
  logic [PHW-1:0] phase;
  logic [BIW-1:0] bitIdx;
  logic [1:0]     syncQ;
  logic           live;
  logic           bitEnd;

  assign lineSync = syncQ[1];
  assign live     = tick && rxEnable && !standby;
  assign bitEnd   = (phase == PHW'(OVERSAMPLE - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], serialIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= '0;
      bitIdx <= '0;
    end else if (standby || !rxEnable) begin
      state <= ST_IDLE;
      phase <= '0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          phase <= '0;
          if (!lineSync && !errAny) state <= ST_START;
        end
        ST_START: begin
          if (phase == PHW'(HALF - 1)) begin
            phase  <= '0;
            bitIdx <= '0;
            state  <= lineSync ? ST_IDLE : ST_DATA;
          end else phase <= phase + 1'b1;
        end
        ST_DATA: begin
          if (bitEnd) begin
            phase <= '0;
            if (bitIdx == BIW'(DATA_BITS - 1)) state <= parityEn ? ST_PAR : ST_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else phase <= phase + 1'b1;
        end
        ST_PAR: begin
          if (bitEnd) begin
            phase <= '0;
            state <= ST_STOP;
          end else phase <= phase + 1'b1;
        end
        ST_STOP: begin
          if (bitEnd) begin
            phase <= '0;
            state <= twoStop ? ST_STOP2 : ST_IDLE;
          end else phase <= phase + 1'b1;
        end
        ST_STOP2: begin
          // skip the rest of stop 1 and all of stop 2, level unchecked
          if (phase == PHW'(OVERSAMPLE + HALF - 1)) begin
            phase <= '0;
            state <= ST_IDLE;
          end else phase <= phase + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.shiftBit   = live && bitEnd && (state == ST_DATA);
    strobe.takeParity = live && bitEnd && (state == ST_PAR);
    strobe.finish     = live && bitEnd && (state == ST_STOP);
  end

  AST_PHASE_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    phase < PHW'(OVERSAMPLE + HALF)); // R1
  AST_START_NEEDS_LOW_MID: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && $past(state) == ST_START) |-> !$past(lineSync)); // R1
  AST_FROZEN_ON_ERROR: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && errAny) |=> (state == ST_IDLE)); // R6
endmodule

// File: rtl/rxDatapath.sv
module rxDatapath
  import rxPkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  standby,
  input  rxStrobeT              strobe,
  input  logic                  lineSync,
  input  logic                  parityEn,
  input  logic                  parityOdd,
  input  logic                  busSel,
  input  logic                  busWrite,
  input  logic                  busAddr,
  input  logic [FLAG_COUNT-1:0] busWdata,
  output logic [7:0]            busRdata,
  output logic                  errAny
);
  logic [DATA_BITS-1:0]  shiftQ;
  logic [DATA_BITS-1:0]  dataQ;
  logic                  parQ;
  logic [FLAG_COUNT-1:0] flagQ;
  logic [FLAG_COUNT-1:0] armQ;
  logic [FLAG_COUNT-1:0] setVec;
  logic                  parFail;
  logic                  frameFail;
  logic                  readStat;
  logic                  writeStat;

  assign readStat  = busSel && !busWrite && busAddr;
  assign writeStat = busSel && busWrite && busAddr;
  assign parFail   = parityEn && ((^{shiftQ, parQ}) != parityOdd);
  assign frameFail = !lineSync;
  assign errAny    = flagQ[FLAG_PAR] || flagQ[FLAG_FRAME];

  always_comb begin
    setVec = '0;
    if (strobe.finish) begin
      setVec[FLAG_FULL]  = !parFail && !frameFail;
      setVec[FLAG_PAR]   = parFail;
      setVec[FLAG_FRAME] = frameFail;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      parQ   <= 1'b0;
      dataQ  <= '0;
    end else begin
      if (strobe.shiftBit)   shiftQ <= {lineSync, shiftQ[DATA_BITS-1:1]};
      if (strobe.takeParity) parQ   <= lineSync;
      if (strobe.finish)     dataQ  <= shiftQ;
    end
  end

  for (genvar i = 0; i < FLAG_COUNT; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagQ[i] <= 1'b0;
        armQ[i]  <= 1'b0;
      end else if (standby) begin
        flagQ[i] <= 1'b0;
        armQ[i]  <= 1'b0;
      end else if (setVec[i]) begin
        flagQ[i] <= 1'b1;
        armQ[i]  <= 1'b0;
      end else if (writeStat && !busWdata[i] && armQ[i]) begin
        flagQ[i] <= 1'b0;
        armQ[i]  <= 1'b0;
      end else if (readStat && flagQ[i]) begin
        armQ[i] <= 1'b1;
      end
    end
  end

  assign busRdata = busAddr ? {{(8-FLAG_COUNT){1'b0}}, flagQ} : 8'(dataQ);

  AST_FULL_ONLY_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ[FLAG_FULL]) |-> !flagQ[FLAG_PAR] && !flagQ[FLAG_FRAME]); // R5
  AST_PAR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ[FLAG_PAR]) |-> $past(parityEn)); // R3
  AST_PAR_CLEAR_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(flagQ[FLAG_PAR]) && !$past(standby)) |-> $past(armQ[FLAG_PAR])); // R7
  AST_FRAME_CLEAR_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(flagQ[FLAG_FRAME]) && !$past(standby)) |-> $past(armQ[FLAG_FRAME])); // R7
  AST_STANDBY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> (flagQ == '0)); // R9
endmodule

// File: rtl/rxChannel.sv
module rxChannel
  import rxPkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       standby,
  input  logic       tick16,
  input  logic       serialIn,
  input  logic       rxEnable,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       twoStop,
  input  logic       busSel,
  input  logic       busWrite,
  input  logic       busAddr,
  input  logic [2:0] busWdata,
  output logic [7:0] busRdata
);
  rxStrobeT strobe;
  logic     lineSync;
  logic     errAny;

  rxCtrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .standby(standby), .tick(tick16),
    .serialIn(serialIn), .rxEnable(rxEnable), .parityEn(parityEn),
    .twoStop(twoStop), .errAny(errAny), .strobe(strobe), .lineSync(lineSync)
  );

  rxDatapath #(.DATA_BITS(DATA_BITS)) i_dp (
    .clk(clk), .rstN(rstN), .standby(standby), .strobe(strobe),
    .lineSync(lineSync), .parityEn(parityEn), .parityOdd(parityOdd),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .errAny(errAny)
  );

  AST_RXEN_OFF_KEEPS_ERRORS: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !standby && !(busSel && busWrite)) |=> $stable(errAny)); // R8
endmodule

// File: tb/test_rxChannel.sv
module test_rxChannel;
  localparam int CLK_PERIOD = 10;
  localparam int OS = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic standby = 1'b0;
  logic tick16 = 1'b1;
  logic serialIn = 1'b1;
  logic rxEnable = 1'b1;
  logic parityEn = 1'b0;
  logic parityOdd = 1'b0;
  logic twoStop = 1'b0;
  logic busSel = 1'b0;
  logic busWrite = 1'b0;
  logic busAddr = 1'b1;
  logic [2:0] busWdata = 3'b000;
  logic [7:0] busRdata;

  int checks = 0;
  int errors = 0;
  logic cmpEn = 1'b0;
  string tag = "R9";

  // reference model
  logic [7:0] expData = 8'h00;
  logic [2:0] expFlags = 3'b000;   // {frame, parity, full}
  logic [2:0] expArm = 3'b000;

  rxChannel i_rxChannel (
    .clk(clk), .rstN(rstN), .standby(standby), .tick16(tick16),
    .serialIn(serialIn), .rxEnable(rxEnable), .parityEn(parityEn),
    .parityOdd(parityOdd), .twoStop(twoStop), .busSel(busSel),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // per-clock comparison against the model (R10 read mux)
  always @(posedge clk) begin
    #1;
    if (cmpEn && rstN) begin
      logic [7:0] exp;
      exp = busAddr ? {5'b0, expFlags} : expData;
      checks++;
      if (busRdata !== exp) begin
        errors++;
        $display("FAIL %s R10 monitor addr=%0d actual=%h expected=%h", tag, busAddr, busRdata, exp);
      end
    end
  end

  task automatic check(input string t, input logic a, input logic [7:0] exp);
    @(negedge clk);
    busAddr = a;
    #1;
    checks++;
    if (busRdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", t, a, busRdata, exp);
    end
    busAddr = 1'b1;
  endtask

  task automatic driveBit(input logic v);
    serialIn = v;
    repeat (OS) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic parFlip,
                           input logic stop1, input logic stop2);
    logic pe, fe;
    @(negedge clk);
    cmpEn = 1'b0;
    driveBit(1'b0);
    for (int i = 0; i < 8; i++) driveBit(d[i]);
    if (parityEn) driveBit((^d) ^ parityOdd ^ parFlip);
    driveBit(stop1);
    if (twoStop) driveBit(stop2);
    serialIn = 1'b1;
    repeat (30) @(negedge clk);
    if (rxEnable && expFlags[2:1] == 2'b00) begin
      pe = parityEn && parFlip;
      fe = !stop1;
      expData = d;
      if (pe) begin expFlags[1] = 1'b1; expArm[1] = 1'b0; end
      if (fe) begin expFlags[2] = 1'b1; expArm[2] = 1'b0; end
      if (!pe && !fe) begin expFlags[0] = 1'b1; expArm[0] = 1'b0; end
    end
    cmpEn = 1'b1;
  endtask

  task automatic readStatus();
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = 1'b1;
    expArm = expArm | expFlags;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic writeStatus(input logic [2:0] v);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = 1'b1; busWdata = v;
    for (int i = 0; i < 3; i++)
      if (expArm[i] && !v[i]) begin expFlags[i] = 1'b0; expArm[i] = 1'b0; end
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic pulseStandby();
    @(negedge clk);
    standby = 1'b1;
    expFlags = 3'b000; expArm = 3'b000;
    @(negedge clk);
    standby = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cmpEn = 1'b1;
    check("R9 reset status", 1'b1, 8'h00);
    check("R9 reset data", 1'b0, 8'h00);

    // R1 glitch rejection
    tag = "R1";
    @(negedge clk); serialIn = 1'b0;
    repeat (4) @(negedge clk); serialIn = 1'b1;
    repeat (60) @(negedge clk);
    check("R1 glitch gives no char", 1'b1, 8'h00);

    // R2 clean frame
    tag = "R2";
    sendFrame(8'hA5, 1'b0, 1'b1, 1'b1);
    check("R2 data lsb first", 1'b0, 8'hA5);
    check("R2 full set", 1'b1, 8'h01);
    tag = "R7";
    readStatus();
    writeStatus(3'b110);
    check("R7 read then write0 clears full, ones ignored", 1'b1, 8'h00);

    sendFrame(8'h3C, 1'b0, 1'b1, 1'b1);
    writeStatus(3'b000);
    check("R7 write0 without read keeps full", 1'b1, 8'h01);
    readStatus(); writeStatus(3'b000);
    check("R7 cleared after read", 1'b1, 8'h00);

    // R3 even parity
    tag = "R3";
    parityEn = 1'b1; parityOdd = 1'b0;
    sendFrame(8'h5A, 1'b0, 1'b1, 1'b1);
    check("R3 even good", 1'b1, 8'h01);
    readStatus(); writeStatus(3'b000);
    sendFrame(8'h5B, 1'b1, 1'b1, 1'b1);
    check("R3 even bad sets parity flag", 1'b1, 8'h02);
    check("R5 data stored on error", 1'b0, 8'h5B);

    // R6 frozen
    tag = "R6";
    sendFrame(8'h11, 1'b0, 1'b1, 1'b1);
    check("R6 frame ignored while error", 1'b0, 8'h5B);
    check("R6 status unchanged", 1'b1, 8'h02);

    // R8 receive-enable does not touch flags
    tag = "R8";
    @(negedge clk); rxEnable = 1'b0;
    repeat (20) @(negedge clk);
    check("R8 flag kept with rx disabled", 1'b1, 8'h02);
    rxEnable = 1'b1;

    tag = "R3";
    readStatus(); writeStatus(3'b000);
    check("R7 parity flag cleared", 1'b1, 8'h00);
    parityOdd = 1'b1;
    sendFrame(8'h77, 1'b0, 1'b1, 1'b1);
    check("R3 odd good", 1'b1, 8'h01);
    check("R3 odd data", 1'b0, 8'h77);
    readStatus(); writeStatus(3'b000);
    sendFrame(8'h80, 1'b1, 1'b1, 1'b1);
    check("R3 odd bad", 1'b1, 8'h02);
    readStatus(); writeStatus(3'b000);

    // R4 framing
    tag = "R4";
    parityEn = 1'b0;
    sendFrame(8'h42, 1'b0, 1'b0, 1'b1);
    check("R4 framing flag", 1'b1, 8'h04);
    check("R5 data stored on framing error", 1'b0, 8'h42);

    tag = "R9";
    pulseStandby();
    check("R9 standby clears flags", 1'b1, 8'h00);

    // R4 two stop bits
    tag = "R4";
    twoStop = 1'b1;
    sendFrame(8'h99, 1'b0, 1'b1, 1'b0);
    repeat (60) @(negedge clk);
    check("R4 second stop ignored", 1'b1, 8'h01);
    check("R4 data after two stop", 1'b0, 8'h99);
    readStatus(); writeStatus(3'b000);
    sendFrame(8'h66, 1'b0, 1'b0, 1'b1);
    check("R4 first stop checked", 1'b1, 8'h04);
    readStatus(); writeStatus(3'b000);
    twoStop = 1'b0;

    // R8 disabled receiver takes nothing
    tag = "R8";
    rxEnable = 1'b0;
    sendFrame(8'hC3, 1'b0, 1'b1, 1'b1);
    check("R8 no char while disabled", 1'b0, 8'h66);
    rxEnable = 1'b1;

    // R6 both errors, partial clear
    tag = "R6";
    parityEn = 1'b1; parityOdd = 1'b0;
    sendFrame(8'h0F, 1'b1, 1'b0, 1'b1);
    check("R6 both flags", 1'b1, 8'h06);
    readStatus(); writeStatus(3'b100);
    check("R7 only parity cleared", 1'b1, 8'h04);
    sendFrame(8'h21, 1'b0, 1'b1, 1'b1);
    check("R6 still frozen with frame flag", 1'b0, 8'h0F);
    writeStatus(3'b000);
    check("R7 frame flag cleared with earlier read", 1'b1, 8'h00);
    sendFrame(8'h21, 1'b0, 1'b1, 1'b1);
    check("R6 resumes after clear", 1'b0, 8'h21);
    check("R6 full after resume", 1'b1, 8'h01);

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule